// File: doc/BRIEF.md
# Fetched-Descriptor Screening Unit

This block sits behind the descriptor fetch path of a multi-channel DMA engine. A fetched descriptor of sixteen 32-bit words arrives one word per accepted cycle, the first word flagged by a start marker. While the words stream past, the unit keeps a running 32-bit wrapping sum and latches the few words it needs. Once the sixteenth word has been taken, it issues a one-cycle result strobe. With that strobe it presents a two-bit verdict, a packed per-channel status word built from the control flags, the line size, the line stride in bytes and the transfer size.

The verdict comes from three screens that run in a fixed priority. The first is a fixed marker byte in the control word. The second is an optional additive checksum carried in the final word. The third is a completion flag in the high timestamp word, which rejects a descriptor that was already consumed unless the descriptor asks for that flag to be ignored. Only the first screen that fails is reported. The fetch itself, the write-back of the completion flag and the payload movement are handled elsewhere.

Word positions in the descriptor: 0 is control, 2 is transfer size, 3 is line size and stride, 5 is the high timestamp, and 15 is the checksum.

Top module: `desc_vetter`

## Requirements
- R1: A word is taken only when `wd_valid_i` is high and either `wd_first_i` is high or a descriptor is open. Valid words that arrive while no descriptor is open are ignored and produce no strobe. A word with `wd_first_i` set always becomes word 0 of a new descriptor.
- R2: `res_valid_o` is high for exactly one cycle, in the cycle after the 16th word (index 15) is taken. The verdict and the decoded outputs keep their values until the next strobe.
- R3: If bits 7:0 of the control word are not 0xA5, the verdict is 1 (marker error).
- R4: If control bit 20 is set and the 32-bit wrapping sum of words 0..14 differs from word 15, the verdict is 2 (checksum error). If bit 20 is clear, word 15 is not compared.
- R5: If bit 31 of word 5 is set and control bit 10 is clear, the verdict is 3 (already consumed). If no screen fails, the verdict is 0 (accepted).
- R6: The screens run in priority order marker, then checksum, then consumed. Only the highest-priority failure is reported.
- R7: The status word carries control bits 7:0 at bits 20:13. It maps control bit 11 to status bit 4, bit 18 to 5, bit 20 to 6, bit 19 to 7, bit 21 to 8, bit 10 to 9, word-5 bit 31 to 10, bit 9 to 11, and bit 8 to 12. All other status bits are 0.
- R8: `line_size_o` is bits 17:0 of word 3. `line_stride_o` is bits 31:18 of word 3 times 16. `xfer_size_o` is word 2.
- R9: During and after reset, `res_valid_o` is 0 and every result output is 0 until the first strobe.
- R10: The running sum restarts at zero when a word with `wd_first_i` arrives, including partway through a descriptor. Words of an abandoned descriptor never reach a checksum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_valid_i | input | 1 | Descriptor word strobe |
| wd_first_i | input | 1 | Marks word 0 of a descriptor |
| wd_data_i | input | 32 | Descriptor word |
| res_valid_o | output | 1 | One-cycle result strobe |
| verdict_o | output | 2 | 0 accepted, 1 marker, 2 checksum, 3 consumed |
| status_o | output | 32 | Packed per-channel status word |
| line_size_o | output | 18 | Line size in bytes |
| line_stride_o | output | 18 | Line stride in bytes |
| xfer_size_o | output | 32 | Transfer size in bytes |

## Verification
The hardest situation to reach is an abandoned descriptor. In that case a new start marker arrives partway through, and the partial sum and any latched fields of the old descriptor must vanish without a strobe. The stimulus sends seven words of a bad-marker descriptor and then a full descriptor with checksum enabled and a correct checksum. It expects exactly one strobe with an accepted verdict. Stray valid words with no start marker and an idle gap inside a descriptor are driven in the same way. Every combination of the three screens, including all failing together, is covered from the vector table.

// File: rtl/dvet_pkg.sv
package dvet_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 16;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    localparam int POS_CTRL = 0;
    localparam int POS_XFER = 2;
    localparam int POS_GEOM = 3;
    localparam int POS_TSHI = 5;
    localparam int POS_SUM  = DESC_WORDS - 1;

    localparam logic [7:0] MARKER = 8'hA5;

    // control word bit positions
    localparam int CB_DONE_IRQ = 8;
    localparam int CB_WRBACK   = 9;
    localparam int CB_IGN_DONE = 10;
    localparam int CB_BURST    = 11;
    localparam int CB_FRAG     = 18;
    localparam int CB_LAST     = 19;
    localparam int CB_SUM_EN   = 20;
    localparam int CB_LAST_FRM = 21;
    localparam int TS_DONE_BIT = 31;

    // status word bit positions
    localparam int SB_BURST    = 4;
    localparam int SB_FRAG     = 5;
    localparam int SB_SUM_EN   = 6;
    localparam int SB_LAST     = 7;
    localparam int SB_LAST_FRM = 8;
    localparam int SB_IGN_DONE = 9;
    localparam int SB_DONE     = 10;
    localparam int SB_WRBACK   = 11;
    localparam int SB_DONE_IRQ = 12;
    localparam int SB_MARK_LSB = 13;

    localparam int LSIZE_W      = 18;
    localparam int STRIDE_RAW_W = WORD_W - LSIZE_W;
    localparam int STRIDE_SHIFT = 4;
    localparam int STRIDE_W     = STRIDE_RAW_W + STRIDE_SHIFT;

    typedef enum logic [1:0] {
        VD_OK       = 2'd0,
        VD_MARKER   = 2'd1,
        VD_CHECKSUM = 2'd2,
        VD_STALE    = 2'd3
    } verdict_t;

    typedef struct packed {
        logic done_irq;
        logic wrback;
        logic ign_done;
        logic burst;
        logic frag;
        logic last;
        logic sum_en;
        logic last_frm;
    } ctl_flags_t;

    typedef struct packed {
        logic [7:0]        mark;
        ctl_flags_t        ctl;
        logic [WORD_W-1:0] xfer;
        logic [WORD_W-1:0] geom;
        logic              ts_done;
    } fields_t;

    typedef struct packed {
        verdict_t              verdict;
        logic [WORD_W-1:0]     status;
        logic [LSIZE_W-1:0]    line_size;
        logic [STRIDE_W-1:0]   stride;
        logic [WORD_W-1:0]     xfer;
    } result_t;

    function automatic ctl_flags_t split_ctl(input logic [WORD_W-1:0] w);
        ctl_flags_t c;
        c.done_irq = w[CB_DONE_IRQ];
        c.wrback   = w[CB_WRBACK];
        c.ign_done = w[CB_IGN_DONE];
        c.burst    = w[CB_BURST];
        c.frag     = w[CB_FRAG];
        c.last     = w[CB_LAST];
        c.sum_en   = w[CB_SUM_EN];
        c.last_frm = w[CB_LAST_FRM];
        return c;
    endfunction

    function automatic verdict_t judge(input fields_t f,
                                       input logic [WORD_W-1:0] sum,
                                       input logic [WORD_W-1:0] chk);
        if (f.mark != MARKER)            return VD_MARKER;
        if (f.ctl.sum_en && sum != chk)  return VD_CHECKSUM;
        if (f.ts_done && !f.ctl.ign_done) return VD_STALE;
        return VD_OK;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input fields_t f);
        logic [WORD_W-1:0] s;
        s = '0;
        s[SB_MARK_LSB +: 8] = f.mark;
        s[SB_BURST]    = f.ctl.burst;
        s[SB_FRAG]     = f.ctl.frag;
        s[SB_SUM_EN]   = f.ctl.sum_en;
        s[SB_LAST]     = f.ctl.last;
        s[SB_LAST_FRM] = f.ctl.last_frm;
        s[SB_IGN_DONE] = f.ctl.ign_done;
        s[SB_DONE]     = f.ts_done;
        s[SB_WRBACK]   = f.ctl.wrback;
        s[SB_DONE_IRQ] = f.ctl.done_irq;
        return s;
    endfunction

endpackage

// File: rtl/dvet_word_track.sv
module dvet_word_track
    import dvet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             first_i,
    output logic             take_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    logic             open_q;
    logic [IDX_W-1:0] next_q;

    assign take_o = valid_i && (first_i || open_q);
    assign idx_o  = first_i ? '0 : next_q;
    assign last_o = take_o && (idx_o == IDX_W'(POS_SUM));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            next_q <= '0;
        end else if (take_o) begin
            open_q <= !last_o;
            next_q <= idx_o + 1'b1;
        end
    end
endmodule

// File: rtl/dvet_sum_acc.sv
module dvet_sum_acc
    import dvet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic              first_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] sum_o
);
    always_ff @(posedge clk) begin
        if (rst)
            sum_o <= '0;
        else if (take_i)
            sum_o <= first_i ? data_i : sum_o + data_i;
    end
endmodule

// File: rtl/dvet_field_latch.sv
module dvet_field_latch
    import dvet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] data_i,
    output fields_t           fields_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fields_o <= '0;
        end else if (take_i) begin
            case (idx_i)
                IDX_W'(POS_CTRL): begin
                    fields_o.mark <= data_i[7:0];
                    fields_o.ctl  <= split_ctl(data_i);
                end
                IDX_W'(POS_XFER): fields_o.xfer    <= data_i;
                IDX_W'(POS_GEOM): fields_o.geom    <= data_i;
                IDX_W'(POS_TSHI): fields_o.ts_done <= data_i[TS_DONE_BIT];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/desc_vetter.sv
module desc_vetter
    import dvet_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wd_valid_i,
    input  logic                wd_first_i,
    input  logic [WORD_W-1:0]   wd_data_i,
    output logic                res_valid_o,
    output logic [1:0]          verdict_o,
    output logic [WORD_W-1:0]   status_o,
    output logic [LSIZE_W-1:0]  line_size_o,
    output logic [STRIDE_W-1:0] line_stride_o,
    output logic [WORD_W-1:0]   xfer_size_o
);
    logic              take;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [WORD_W-1:0] sum;
    fields_t           fields;
    result_t           res_q;
    logic              res_valid_q;

    dvet_word_track u_track (
        .clk     (clk),
        .rst     (rst),
        .valid_i (wd_valid_i),
        .first_i (wd_first_i),
        .take_o  (take),
        .idx_o   (idx),
        .last_o  (last)
    );

    dvet_sum_acc u_sum (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .first_i (wd_first_i),
        .data_i  (wd_data_i),
        .sum_o   (sum)
    );

    dvet_field_latch u_fields (
        .clk      (clk),
        .rst      (rst),
        .take_i   (take),
        .idx_i    (idx),
        .data_i   (wd_data_i),
        .fields_o (fields)
    );

    // word 15 is still on the bus when the last word is taken;
    // sum holds words 0..14 at that moment
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q       <= '0;
            res_valid_q <= 1'b0;
        end else begin
            res_valid_q <= last;
            if (last) begin
                res_q.verdict   <= judge(fields, sum, wd_data_i);
                res_q.status    <= pack_status(fields);
                res_q.line_size <= fields.geom[LSIZE_W-1:0];
                res_q.stride    <= {fields.geom[WORD_W-1:LSIZE_W], {STRIDE_SHIFT{1'b0}}};
                res_q.xfer      <= fields.xfer;
            end
        end
    end

    assign res_valid_o   = res_valid_q;
    assign verdict_o     = res_q.verdict;
    assign status_o      = res_q.status;
    assign line_size_o   = res_q.line_size;
    assign line_stride_o = res_q.stride;
    assign xfer_size_o   = res_q.xfer;
endmodule

// File: rtl/desc_vetter_chk.sv
module desc_vetter_chk (
    input logic       clk,
    input logic       rst,
    input logic       res_valid,
    input logic [1:0] verdict,
    input logic [7:0] st_mark,
    input logic       st_sum_en,
    input logic       st_ign_done,
    input logic       st_done,
    input logic [3:0] stride_lo
);
    // 16 words per descriptor: a strobe can never repeat on the next cycle
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> !res_valid);

    assert_marker_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && st_mark != 8'hA5) |-> verdict == 2'd1);

    assert_marker_first_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && verdict != 2'd1) |-> st_mark == 8'hA5);

    assert_checksum_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && verdict == 2'd2) |-> st_sum_en);

    assert_stale_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && verdict == 2'd3) |-> (st_done && !st_ign_done));

    assert_stale_caught_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && st_mark == 8'hA5 && st_done && !st_ign_done && verdict != 2'd2)
        |-> verdict == 2'd3);

    assert_stride_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> stride_lo == 4'd0);
endmodule

bind desc_vetter desc_vetter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .res_valid   (res_valid_o),
    .verdict     (verdict_o),
    .st_mark     (status_o[20:13]),
    .st_sum_en   (status_o[6]),
    .st_ign_done (status_o[9]),
    .st_done     (status_o[10]),
    .stride_lo   (line_stride_o[3:0])
);

// File: tb/test_desc_vetter.sv
module test_desc_vetter;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] ts;
        logic [31:0] geom;
        logic [31:0] xfer;
        logic        bad;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00A5, 32'h0000_0000, 32'h0004_0040, 32'h0000_1000, 1'b0, 2'd0},
        '{32'h0010_00A5, 32'h0000_1234, 32'h0008_0100, 32'h0000_2000, 1'b0, 2'd0},
        '{32'h0010_00A5, 32'h0000_0000, 32'h0010_0200, 32'h0000_0800, 1'b1, 2'd2},
        '{32'h0000_00A4, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd1},
        '{32'h0010_00A4, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1, 2'd1},
        '{32'h0000_00A5, 32'h8000_0000, 32'h0014_0300, 32'h0000_0300, 1'b0, 2'd3},
        '{32'h0000_04A5, 32'h8000_0000, 32'h0018_0400, 32'h0000_0400, 1'b0, 2'd0},
        '{32'h0010_00A5, 32'h8000_0000, 32'h001C_0500, 32'h0000_0500, 1'b1, 2'd2},
        '{32'h003C_0FA5, 32'h8000_0000, 32'hABCD_E123, 32'h0001_0000, 1'b0, 2'd0},
        '{32'h0000_085A, 32'h0000_0000, 32'h0040_0040, 32'h0000_0040, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wd_valid = 1'b0;
    logic        wd_first = 1'b0;
    logic [31:0] wd_data = '0;
    logic        res_valid;
    logic [1:0]  verdict;
    logic [31:0] status;
    logic [17:0] line_size;
    logic [17:0] line_stride;
    logic [31:0] xfer_size;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic [31:0] dw [16];

    always #2.5 clk = ~clk;

    desc_vetter i_desc_vetter (
        .clk           (clk),
        .rst           (rst),
        .wd_valid_i    (wd_valid),
        .wd_first_i    (wd_first),
        .wd_data_i     (wd_data),
        .res_valid_o   (res_valid),
        .verdict_o     (verdict),
        .status_o      (status),
        .line_size_o   (line_size),
        .line_stride_o (line_stride),
        .xfer_size_o   (xfer_size)
    );

    always @(posedge clk) if (!rst && res_valid) strobes++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] c, input logic [31:0] t);
        logic [31:0] s = '0;
        s[20:13] = c[7:0];
        s[4]  = c[11];
        s[5]  = c[18];
        s[6]  = c[20];
        s[7]  = c[19];
        s[8]  = c[21];
        s[9]  = c[10];
        s[10] = t[31];
        s[11] = c[9];
        s[12] = c[8];
        return s;
    endfunction

    task automatic build(input vec_t v, input int seed);
        logic [31:0] acc = '0;
        for (int i = 0; i < 15; i++) begin
            dw[i] = 32'h1357_9BDF * (i + 1) + seed;
        end
        dw[0] = v.ctrl;
        dw[2] = v.xfer;
        dw[3] = v.geom;
        dw[5] = v.ts;
        for (int i = 0; i < 15; i++) acc = acc + dw[i];
        dw[15] = v.bad ? acc + 32'd1 : acc;
    endtask

    task automatic send(input int nwords, input bit gap);
        for (int i = 0; i < nwords; i++) begin
            if (gap && i == 7) begin
                @(negedge clk);
                wd_valid = 1'b0;
                wd_first = 1'b0;
            end
            @(negedge clk);
            wd_valid = 1'b1;
            wd_first = (i == 0);
            wd_data  = dw[i];
        end
        @(negedge clk);
        wd_valid = 1'b0;
        wd_first = 1'b0;
    endtask

    task automatic check_result(input vec_t v, input string tag);
        chk({tag, " R2 strobe"}, 64'(res_valid), 64'd1);
        chk({tag, " R3/R4/R5/R6 verdict"}, 64'(verdict), 64'(v.exp));
        chk({tag, " R7 status"}, 64'(status), 64'(exp_status(v.ctrl, v.ts)));
        chk({tag, " R8 line size"}, 64'(line_size), 64'(v.geom[17:0]));
        chk({tag, " R8 stride"}, 64'(line_stride), 64'({v.geom[31:18], 4'b0}));
        chk({tag, " R8 xfer"}, 64'(xfer_size), 64'(v.xfer));
        @(negedge clk);
        chk({tag, " R2 strobe drop"}, 64'(res_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 strobe in reset", 64'(res_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 strobe after reset", 64'(res_valid), 64'd0);
        chk("R9 verdict after reset", 64'(verdict), 64'd0);
        chk("R9 status after reset", 64'(status), 64'd0);
        chk("R9 xfer after reset", 64'(xfer_size), 64'd0);

        // vector table
        for (int n = 0; n < NV; n++) begin
            build(VECS[n], n * 7);
            send(16, n == 4);
            check_result(VECS[n], $sformatf("vec%0d", n));
        end

        // R2 hold: outputs keep last result
        repeat (5) @(negedge clk);
        chk("R2 hold verdict", 64'(verdict), 64'(VECS[NV-1].exp));
        chk("R2 hold status", 64'(status), 64'(exp_status(VECS[NV-1].ctrl, VECS[NV-1].ts)));

        // R1 stray words without start marker are ignored
        s0 = strobes;
        build(VECS[3], 99);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            wd_valid = 1'b1;
            wd_first = 1'b0;
            wd_data  = dw[i % 16];
        end
        @(negedge clk);
        wd_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 stray no strobe", 64'(strobes - s0), 64'd0);
        chk("R1 stray outputs untouched", 64'(status),
            64'(exp_status(VECS[NV-1].ctrl, VECS[NV-1].ts)));
        build(VECS[0], 5);
        send(16, 1'b0);
        check_result(VECS[0], "R1 after stray");

        // R10 restart mid-descriptor
        s0 = strobes;
        build(VECS[3], 11);
        send(7, 1'b0);
        build(VECS[1], 23);
        send(16, 1'b0);
        check_result(VECS[1], "R10 restart");
        chk("R10 single strobe", 64'(strobes - s0), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule